// File: doc/BRIEF.md
# Framed Serial Transmitter

This block serialises characters from a transmit queue onto a single line. A writer pushes characters into a 16-entry queue. The two queue flags let the writer avoid blocking: one flag reports that the queue is full, and the other reports that nothing is left queued, which is how a flush is detected. The serialiser takes one character at a time. It sends the character as an asynchronous frame and paces every bit by an external tick that runs at sixteen times the bit rate.

The frame format can be changed at run time through four controls: word length (5 to 8 bits), parity on or off, parity sense, and one or two stop bits. The serialiser takes a snapshot of the format as each frame starts. A change made in the middle of a frame therefore takes effect from the next character. The line is driven only while both the global enable and the transmit enable are high. If either enable is dropped, the line returns to idle at once.

Top module: `serial_tx_core`

## Requirements
- R1: After reset the line output is high, the empty flag is 1 and the full flag is 0.
- R2: Each frame starts with a low start bit. The data bits follow, least significant first, and their count is set by `word_len_i`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. The frame closes with high stop bit(s).
- R3: Every bit of a frame, including start, parity and stop bits, stays on the line for exactly 16 ticks of `tick16_i`.
- R4: When `par_en_i` is 1, a parity bit is sent after the data bits. With `par_even_i` = 1 the data bits plus the parity bit hold an even number of ones. With `par_even_i` = 0 they hold an odd number. When `par_en_i` is 0, no parity bit is sent.
- R5: `two_stop_i` = 1 sends two stop bits and `two_stop_i` = 0 sends one.
- R6: The full flag is 1 while 16 characters are queued. A write made while the queue is full is dropped. Each accepted write queues bits [7:0] of `wr_data_i`.
- R7: The empty flag is 1 exactly when no character is queued. It rises as soon as the last character leaves the queue, even while that character is still being sent.
- R8: A frame starts only while `uart_en_i` and `tx_en_i` are both 1. Otherwise the line stays high and the queued characters are kept.
- R9: If either enable falls during a frame, the line goes high on the next clock. The character being sent is discarded, and the next frame starts with the following queued character.
- R10: The frame format is captured when a frame starts. A change to the format controls during a frame affects only later frames.
- R11: Characters are sent in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uart_en_i | input | 1 | Global enable |
| tx_en_i | input | 1 | Transmit enable |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_valid_i | input | 1 | Write strobe into the queue |
| wr_data_i | input | WDATA_W (16) | Write data; only the low 8 bits are queued |
| word_len_i | input | 2 | Data bit count code |
| par_en_i | input | 1 | Parity bit enable |
| par_even_i | input | 1 | 1 selects even parity, 0 selects odd parity |
| two_stop_i | input | 1 | 1 selects two stop bits |
| fifo_full_o | output | 1 | Queue holds 16 characters |
| fifo_empty_o | output | 1 | Queue holds no characters |
| txd_o | output | 1 | Serial line, idles high |

## Verification
A wrong bit-phase count shows up quickly. The line then moves a tick early or late, and the error grows over the frame, so sampling at both the first and the last tick of every bit exposes it within a single frame. A wrong queue pointer or count appears at the flags within one clock of a write. It also appears at the line as a lost, repeated or reordered character at the next frame. A format snapshot taken at the wrong moment changes the length of the frame that is in flight, and the frame check catches that at its stop bits.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } stx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       two_stop;
  } stx_fmt_t;
endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end
endmodule

// File: rtl/stx_bit_timer.sv
module stx_bit_timer #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic bit_end_o
);
  localparam int TW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;

  logic [TW-1:0] cnt_q;

  assign bit_end_o = tick_i && (cnt_q == TW'(OVERSAMPLE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clear_i)   cnt_q <= '0;
    else if (bit_end_o) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/stx_serializer.sv
module stx_serializer
  import stx_pkg::*;
#(
  parameter int DW         = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          avail_i,
  input  logic [DW-1:0] data_i,
  input  stx_fmt_t      fmt_i,
  input  logic          tick_i,
  output logic          pop_o,
  output logic          txd_o
);
  localparam int IW = $clog2(DW);

  stx_state_e    state_q;
  stx_fmt_t      fmt_q;
  logic [DW-1:0] shreg_q;
  logic [IW-1:0] bit_idx_q;
  logic          par_q, stop2_q;
  logic          load, bit_end;
  logic [IW-1:0] last_in, last_q;
  logic [DW-1:0] masked;

  assign load    = (state_q == ST_IDLE) && run_i && avail_i;
  assign pop_o   = load;
  assign last_in = IW'(DW - 4) + IW'(fmt_i.wlen);
  assign last_q  = IW'(DW - 4) + IW'(fmt_q.wlen);

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign masked[i] = data_i[i] & (IW'(i) <= last_in);
  end

  stx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  ((state_q == ST_IDLE) || !run_i),
    .tick_i   (tick_i),
    .bit_end_o(bit_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      fmt_q     <= '0;
      shreg_q   <= '0;
      bit_idx_q <= '0;
      par_q     <= 1'b0;
      stop2_q   <= 1'b0;
      txd_o     <= 1'b1;
    end else if (!run_i) begin
      state_q <= ST_IDLE;
      txd_o   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (avail_i) begin
          shreg_q   <= data_i;
          fmt_q     <= fmt_i;
          par_q     <= fmt_i.par_even ? ^masked : ~^masked;
          bit_idx_q <= '0;
          state_q   <= ST_START;
          txd_o     <= 1'b0;
        end
        ST_START: if (bit_end) begin
          txd_o   <= shreg_q[0];
          shreg_q <= shreg_q >> 1;
          state_q <= ST_DATA;
        end
        ST_DATA: if (bit_end) begin
          if (bit_idx_q == last_q) begin
            stop2_q <= 1'b0;
            if (fmt_q.par_en) begin
              txd_o   <= par_q;
              state_q <= ST_PAR;
            end else begin
              txd_o   <= 1'b1;
              state_q <= ST_STOP;
            end
          end else begin
            bit_idx_q <= bit_idx_q + IW'(1);
            txd_o     <= shreg_q[0];
            shreg_q   <= shreg_q >> 1;
          end
        end
        ST_PAR: if (bit_end) begin
          txd_o   <= 1'b1;
          state_q <= ST_STOP;
        end
        ST_STOP: if (bit_end) begin
          if (fmt_q.two_stop && !stop2_q) stop2_q <= 1'b1;
          else                            state_q <= ST_IDLE;
        end
        default: begin
          state_q <= ST_IDLE;
          txd_o   <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import stx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CHAR_W     = 8,
  parameter int WDATA_W    = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               uart_en_i,
  input  logic               tx_en_i,
  input  logic               tick16_i,
  input  logic               wr_valid_i,
  input  logic [WDATA_W-1:0] wr_data_i,
  input  logic [1:0]         word_len_i,
  input  logic               par_en_i,
  input  logic               par_even_i,
  input  logic               two_stop_i,
  output logic               fifo_full_o,
  output logic               fifo_empty_o,
  output logic               txd_o
);
  logic              run, pop;
  logic [CHAR_W-1:0] head;
  stx_fmt_t          fmt;
  logic              unused_hi;

  assign run       = uart_en_i && tx_en_i;
  assign fmt       = '{wlen: word_len_i, par_en: par_en_i,
                       par_even: par_even_i, two_stop: two_stop_i};
  assign unused_hi = ^wr_data_i[WDATA_W-1:CHAR_W];

  stx_fifo #(.DW(CHAR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (wr_valid_i),
    .push_data_i(wr_data_i[CHAR_W-1:0]),
    .pop_i      (pop),
    .head_o     (head),
    .full_o     (fifo_full_o),
    .empty_o    (fifo_empty_o)
  );

  stx_serializer #(.DW(CHAR_W), .OVERSAMPLE(OVERSAMPLE)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .avail_i(!fifo_empty_o),
    .data_i (head),
    .fmt_i  (fmt),
    .tick_i (tick16_i),
    .pop_o  (pop),
    .txd_o  (txd_o)
  );
endmodule

// File: rtl/stx_chk.sv
module stx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic uart_en_i,
  input logic tx_en_i,
  input logic tick16_i,
  input logic wr_valid_i,
  input logic fifo_full_o,
  input logic fifo_empty_o,
  input logic txd_o
);
  // R8
  line_idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(uart_en_i && tx_en_i) |=> txd_o);

  // R3
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_en_i && tx_en_i && !tick16_i && fifo_empty_o) |=> $stable(txd_o));

  // R6
  full_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full_o && !(uart_en_i && tx_en_i)) |=> fifo_full_o);

  // R7
  empty_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_empty_o && !wr_valid_i) |=> fifo_empty_o);

  // R6
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_full_o && fifo_empty_o));
endmodule

bind serial_tx_core stx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .uart_en_i   (uart_en_i),
  .tx_en_i     (tx_en_i),
  .tick16_i    (tick16_i),
  .wr_valid_i  (wr_valid_i),
  .fifo_full_o (fifo_full_o),
  .fifo_empty_o(fifo_empty_o),
  .txd_o       (txd_o)
);

// File: tb/tb_serial_tx_core.sv
module tb_serial_tx_core;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        uart_en = 1'b0, tx_en = 1'b0, tick = 1'b0, wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wlen = 2'b11;
  logic        par_en = 1'b0, par_even = 1'b0, two_stop = 1'b0;
  logic        full, empty, txd;

  int n_chk = 0, n_fail = 0, cyc = 0, tcnt = 0, div = 0;
  logic [7:0] q[$];

  serial_tx_core dut (
    .clk_i(clk), .rst_ni(rst_n), .uart_en_i(uart_en), .tx_en_i(tx_en),
    .tick16_i(tick), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .word_len_i(wlen), .par_en_i(par_en), .par_even_i(par_even),
    .two_stop_i(two_stop), .fifo_full_o(full), .fifo_empty_o(empty),
    .txd_o(txd)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    if (tick) tcnt <= tcnt + 1;
    div  <= (div == 3) ? 0 : div + 1;
    tick <= (div == 3);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int nbits(input logic [1:0] wl);
    return 5 + int'(wl);
  endfunction

  function automatic int flen(input logic [1:0] wl, input logic pe, input logic ts);
    return 2 + nbits(wl) + int'(pe) + int'(ts);
  endfunction

  function automatic logic exp_bit(input logic [7:0] d, input logic [1:0] wl,
                                   input logic pe, input logic ev, input int k);
    int nb = nbits(wl);
    int ones = 0;
    if (k == 0) return 1'b0;
    if (k <= nb) return d[k-1];
    if (pe && k == nb + 1) begin
      for (int i = 0; i < nb; i++) ones += int'(d[i]);
      return ev ? logic'(ones % 2) : ~logic'(ones % 2);
    end
    return 1'b1;
  endfunction

  task automatic wait_t(input int target);
    while (tcnt < target) @(negedge clk);
  endtask

  // receive one frame and check it against the given format and byte
  task automatic rx_frame(input logic [7:0] d, input logic [1:0] wl,
                          input logic pe, input logic ev, input logic ts);
    int g = 0, s, n, nb;
    string req;
    logic e;
    while (txd !== 1'b0 && g < 20000) begin @(negedge clk); g++; end
    check(g < 20000, "R2 start", int'(txd), 0);
    s  = tcnt;
    n  = flen(wl, pe, ts);
    nb = nbits(wl);
    for (int k = 0; k < n; k++) begin
      e = exp_bit(d, wl, pe, ev, k);
      if (k <= nb) req = "R2";
      else if (pe && k == nb + 1) req = "R4";
      else req = "R5";
      wait_t(s + 16*k + 1);
      check(txd === e, req, int'(txd), int'(e));
      wait_t(s + 16*k + 15);
      check(txd === e, "R3", int'(txd), int'(e));
    end
  endtask

  task automatic wr(input logic [15:0] v);
    wr_data = v; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic line_high(input int cycles, input string req);
    bit ok = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) ok = 1'b0;
    end
    check(ok, req, int'(ok), 1);
  endtask

  initial begin
    wait (cyc > 190000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] b, b2;
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    // R1
    check(txd === 1'b1, "R1 txd", int'(txd), 1);
    check(empty === 1'b1, "R1 empty", int'(empty), 1);
    check(full === 1'b0, "R1 full", int'(full), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill while transmit disabled; extra writes dropped
    uart_en = 1'b1; tx_en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      logic [15:0] v = 16'($urandom);
      if (i < 16) q.push_back(v[7:0]);
      wr(v);
      if (i == 0) check(empty === 1'b0, "R7 not empty", int'(empty), 0);
      if (i == 14) check(full === 1'b0, "R6 not yet full", int'(full), 0);
      if (i == 15) check(full === 1'b1, "R6 full", int'(full), 1);
    end
    line_high(100, "R8 tx_en low");
    uart_en = 1'b0; tx_en = 1'b1;
    line_high(300, "R8 uart_en low");
    check(full === 1'b1, "R8 queue kept", int'(full), 1);

    // drain in order at 8N1
    uart_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      b = q.pop_front();
      rx_frame(b, 2'b11, 1'b0, 1'b0, 1'b0);
      if (i == 0) check(full === 1'b0, "R6 full clears", int'(full), 0);
      if (i == 15) check(empty === 1'b1, "R7 empty on last", int'(empty), 1);
    end
    line_high(2000, "R6 dropped writes");
    check(empty === 1'b1, "R7 empty idle", int'(empty), 1);

    // directed formats
    tx_en = 1'b0;
    wlen = 2'b10; par_en = 1'b1; par_even = 1'b1; two_stop = 1'b0;
    wr(16'hA5F3);
    tx_en = 1'b1; rx_frame(8'hF3, 2'b10, 1'b1, 1'b1, 1'b0);
    tx_en = 1'b0;
    wlen = 2'b00; par_en = 1'b1; par_even = 1'b0; two_stop = 1'b1;
    wr(16'h00E3);
    tx_en = 1'b1; rx_frame(8'hE3, 2'b00, 1'b1, 1'b0, 1'b1);

    // random formats
    for (int r = 0; r < 12; r++) begin
      int cnt = 1 + int'($urandom % 5);
      tx_en = 1'b0;
      wlen = 2'($urandom); par_en = 1'($urandom);
      par_even = 1'($urandom); two_stop = 1'($urandom);
      for (int i = 0; i < cnt; i++) begin
        logic [15:0] v = 16'($urandom);
        q.push_back(v[7:0]);
        wr(v);
      end
      tx_en = 1'b1;
      for (int i = 0; i < cnt; i++) begin
        b = q.pop_front();
        rx_frame(b, wlen, par_en, par_even, two_stop);
      end
    end

    // R10: format changed mid-frame applies to next frame only
    tx_en = 1'b0;
    wlen = 2'b11; par_en = 1'b0; par_even = 1'b0; two_stop = 1'b0;
    wr(16'h0096); wr(16'h003C);
    tx_en = 1'b1;
    fork
      rx_frame(8'h96, 2'b11, 1'b0, 1'b0, 1'b0);
      begin
        wait_t(tcnt + 40);
        wlen = 2'b01; par_en = 1'b1; par_even = 1'b1; two_stop = 1'b1;
      end
    join
    rx_frame(8'h3C, 2'b01, 1'b1, 1'b1, 1'b1);
    check(1'b1, "R10 format snapshot", 1, 1);

    // R9: abort mid-frame
    tx_en = 1'b0;
    wlen = 2'b11; par_en = 1'b0; two_stop = 1'b0;
    b = 8'($urandom); b2 = 8'($urandom);
    wr(16'h0011); wr({8'h00, b}); wr({8'h00, b2});
    tx_en = 1'b1;
    while (txd !== 1'b0) @(negedge clk);
    wait_t(tcnt + 50);
    tx_en = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R9 abort next clock", int'(txd), 1);
    line_high(300, "R9 stays idle");
    check(empty === 1'b0, "R9 rest kept", int'(empty), 0);
    tx_en = 1'b1;
    rx_frame(b, 2'b11, 1'b0, 1'b0, 1'b0);
    rx_frame(b2, 2'b11, 1'b0, 1'b0, 1'b0);
    check(empty === 1'b1, "R11 R9 order after abort", int'(empty), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule